// File: doc/BRIEF.md
# Windowed Watchdog with Write-Once Configuration

This block is a watchdog timer that issues a reset request when software stops servicing it. Its timeout comes from a 2-bit period code together with a clock-source choice. The counter advances either on a slow low-power tick strobe (nominally one per millisecond) or on a bus-clock enable strobe. A period code of zero switches the watchdog off. The overflow point is a power of two whose exponent depends on the code and the source; all six exponents are parameters. By default they are 5, 8 and 10 for the tick and 13, 16 and 18 for the bus clock.

The configuration byte is locked by its first write after reset. The source select and the window enable arrive on separate inputs and are captured by that same write. The byte also holds a stop-enable bit and two routing option bits. These are stored and read back, and the stop-enable bit governs what happens on a stop request.

With the bus clock selected, window mode treats a service made before the final quarter of the period as a fault. Any fault produces a one-cycle reset pulse that carries a cause code, and the counter then restarts from zero.

Top module: `win_watchdog`

## Requirements
- R1: After reset, `cfg_rdata` reads 0xC0, and the source and window selections are both 0. The first `cfg_we` stores `cfg_wdata[7:3]` and captures `cfg_src_bus` and `cfg_window` in the same cycle. Bits 2:0 always read as zero.
- R2: Once the first write has happened, every later `cfg_we` is ignored until the next reset. This covers the data and both captured selections.
- R3: When the period code in bits 7:6 is 00, the counter is held at zero and no overflow or early-service pulse is produced, whatever the source select and ticks.
- R4: With `cfg_src_bus`=0, only `tick_lp` advances the counter. The period is 2^LP_E1, 2^LP_E2 or 2^LP_E3 ticks for codes 01, 10 and 11. On the clock edge that takes in the last tick of the period, `rst_pulse` rises for one cycle with `rst_cause`=0 (overflow), and the counter restarts at zero.
- R5: With `cfg_src_bus`=1, only `tick_bus` advances the counter. The period is 2^BUS_E1, 2^BUS_E2 or 2^BUS_E3 strobes for codes 01, 10 and 11.
- R6: A service is a `svc_we` write of 0x55 followed directly by a `svc_we` write of 0xAA, with no other service-port write between them. A complete service clears the counter, and any other sequence leaves the count untouched.
- R7: When the window is enabled and the bus source is selected, a service completed while the count is below three quarters of the period raises `rst_pulse` with `rst_cause`=1 (early service). A service at or above that count clears the counter quietly.
- R8: A valid service completed in the same cycle as the overflow tick takes precedence. No pulse is produced and the counter restarts from zero.
- R9: When bit 5 (stop enable) is 1, `stop_req` gives a one-cycle `stop_go` on the next edge. When bit 5 is 0, `stop_req` instead gives `rst_pulse` with `rst_cause`=2 (illegal stop), even while the watchdog is disabled.
- R10: An illegal stop takes priority over an overflow in the same cycle. Exactly one pulse is produced, with cause 2, and the counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_lp | input | 1 | Low-power tick enable strobe |
| tick_bus | input | 1 | Bus-clock enable strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_src_bus | input | 1 | Source select captured on the first write (1 = bus) |
| cfg_window | input | 1 | Window enable captured on the first write |
| cfg_rdata | output | 8 | Configuration read-back |
| svc_we | input | 1 | Service port write strobe |
| svc_data | input | 8 | Service port data |
| stop_req | input | 1 | Request to enter stop |
| stop_go | output | 1 | Stop granted (registered pulse) |
| rst_pulse | output | 1 | Reset request pulse (registered) |
| rst_cause | output | 2 | Cause of the pulse: 0 overflow, 1 early service, 2 illegal stop |

## Verification
Two events can land on the same clock edge: the tick that ends the period, and either the closing 0xAA of a service or a stop request made while stop is disabled. The bench counts the counter up to one short of its limit. It then asserts the final tick in the very cycle the 0xAA write or the stop request arrives. In the service case it expects no pulse. In the stop case it expects a single pulse with cause 2. In both cases it confirms that a fresh full period follows, before the next overflow appears.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    CAUSE_OVF   = 2'd0,
    CAUSE_EARLY = 2'd1,
    CAUSE_STOP  = 2'd2
  } cause_e;

  localparam logic [7:0] KEY_ARM   = 8'h55;
  localparam logic [7:0] KEY_FIRE  = 8'hAA;
  localparam logic [7:0] CFG_INIT  = 8'hC0;
  localparam logic [7:0] CFG_MASK  = 8'hF8;
endpackage

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       src_in,
  input  logic       win_in,
  output logic [7:0] rdata,
  output logic [1:0] code,
  output logic       stop_en,
  output logic       src_bus,
  output logic       win_en,
  output logic       locked
);
  logic [7:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_INIT;
      src_bus <= 1'b0;
      win_en  <= 1'b0;
      locked  <= 1'b0;
    end else if (we && !locked) begin
      cfg_q   <= wdata & CFG_MASK;
      src_bus <= src_in;
      win_en  <= win_in;
      locked  <= 1'b1;
    end
  end

  assign rdata   = cfg_q;
  assign code    = cfg_q[7:6];
  assign stop_en = cfg_q[5];
endmodule

// File: rtl/wdg_svc_seq.sv
module wdg_svc_seq
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] data,
  output logic       done
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst)     armed_q <= 1'b0;
    else if (we) armed_q <= (data == KEY_ARM);
  end

  assign done = we && armed_q && (data == KEY_FIRE);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned LP_E1  = 5,
  parameter int unsigned LP_E2  = 8,
  parameter int unsigned LP_E3  = 10,
  parameter int unsigned BUS_E1 = 13,
  parameter int unsigned BUS_E2 = 16,
  parameter int unsigned BUS_E3 = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] code,
  input  logic       src_bus,
  input  logic       tick_lp,
  input  logic       tick_bus,
  input  logic       clr,
  output logic       tick_sel,
  output logic       at_limit,
  output logic       in_guard
);
  localparam int unsigned TOP_E = (BUS_E3 > LP_E3) ? BUS_E3 : LP_E3;
  localparam int unsigned CW    = TOP_E + 1;
  localparam int unsigned LP_EXP  [4] = '{0, LP_E1, LP_E2, LP_E3};
  localparam int unsigned BUS_EXP [4] = '{0, BUS_E1, BUS_E2, BUS_E3};

  logic [CW-1:0] per_lp   [4];
  logic [CW-1:0] per_bus  [4];
  logic [CW-1:0] open_bus [4];

  for (genvar g = 0; g < 4; g++) begin : g_code
    if (g == 0) begin : g_off
      assign per_lp[g]   = '0;
      assign per_bus[g]  = '0;
      assign open_bus[g] = '0;
    end else begin : g_on
      assign per_lp[g]   = CW'(1) << LP_EXP[g];
      assign per_bus[g]  = CW'(1) << BUS_EXP[g];
      assign open_bus[g] = per_bus[g] - (per_bus[g] >> 2);
    end
  end

  logic          en;
  logic [CW-1:0] lim, wopen, cnt_q;

  assign en       = (code != 2'd0);
  assign tick_sel = src_bus ? tick_bus : tick_lp;

  always_comb begin
    lim   = src_bus ? per_bus[code] : per_lp[code];
    wopen = src_bus ? open_bus[code] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en)    cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (tick_sel) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = en && (cnt_q >= lim - 1'b1);
  assign in_guard = en && (cnt_q < wopen);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned LP_E1  = 5,
  parameter int unsigned LP_E2  = 8,
  parameter int unsigned LP_E3  = 10,
  parameter int unsigned BUS_E1 = 13,
  parameter int unsigned BUS_E2 = 16,
  parameter int unsigned BUS_E3 = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_lp,
  input  logic       tick_bus,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       cfg_src_bus,
  input  logic       cfg_window,
  output logic [7:0] cfg_rdata,
  input  logic       svc_we,
  input  logic [7:0] svc_data,
  input  logic       stop_req,
  output logic       stop_go,
  output logic       rst_pulse,
  output logic [1:0] rst_cause
);
  logic [1:0] code;
  logic       stop_en, src_bus, win_en, cfg_locked;
  logic       svc_done, tick_sel, at_limit, in_guard;
  logic       illegal, early_f, good_svc, ovf, fire, clr;
  cause_e     cause;

  wdg_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .src_in(cfg_src_bus), .win_in(cfg_window), .rdata(cfg_rdata),
    .code(code), .stop_en(stop_en), .src_bus(src_bus),
    .win_en(win_en), .locked(cfg_locked)
  );

  wdg_svc_seq u_svc (
    .clk(clk), .rst(rst), .we(svc_we), .data(svc_data), .done(svc_done)
  );

  wdg_counter #(
    .LP_E1(LP_E1), .LP_E2(LP_E2), .LP_E3(LP_E3),
    .BUS_E1(BUS_E1), .BUS_E2(BUS_E2), .BUS_E3(BUS_E3)
  ) u_cnt (
    .clk(clk), .rst(rst), .code(code), .src_bus(src_bus),
    .tick_lp(tick_lp), .tick_bus(tick_bus), .clr(clr),
    .tick_sel(tick_sel), .at_limit(at_limit), .in_guard(in_guard)
  );

  always_comb begin
    illegal  = stop_req && !stop_en;
    early_f  = svc_done && win_en && in_guard;
    good_svc = svc_done && (code != 2'd0) && !early_f;
    ovf      = tick_sel && at_limit && !good_svc;
    fire     = illegal || early_f || ovf;
    clr      = fire || good_svc;
    if (illegal)      cause = CAUSE_STOP;
    else if (early_f) cause = CAUSE_EARLY;
    else              cause = CAUSE_OVF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pulse <= 1'b0;
      rst_cause <= 2'd0;
      stop_go   <= 1'b0;
    end else begin
      rst_pulse <= fire;
      rst_cause <= fire ? cause : 2'd0;
      stop_go   <= stop_req && stop_en;
    end
  end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
  input logic       clk,
  input logic       rst,
  input logic       stop_req,
  input logic [7:0] cfg_rdata,
  input logic       rst_pulse,
  input logic [1:0] rst_cause,
  input logic       stop_go,
  input logic       locked
);
  // R1
  rd_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[2:0] == 3'b000);

  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(cfg_rdata));

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[7:6] == 2'b00 && !stop_req) |=> !rst_pulse);

  // R9
  stop_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_req && cfg_rdata[5]) |=> (stop_go && !(rst_pulse && rst_cause == 2'd2)));

  // R10
  illegal_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !cfg_rdata[5]) |=> (rst_pulse && rst_cause == 2'd2 && !stop_go));

  // R4
  cause_legal_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |-> rst_cause != 2'd3);
endmodule

bind win_watchdog wdg_checker u_chk (
  .clk(clk), .rst(rst), .stop_req(stop_req), .cfg_rdata(cfg_rdata),
  .rst_pulse(rst_pulse), .rst_cause(rst_cause), .stop_go(stop_go),
  .locked(cfg_locked)
);

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int LE1 = 2, LE2 = 3, LE3 = 4;
  localparam int BE1 = 4, BE2 = 5, BE3 = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic tick_lp = 0, tick_bus = 0, cfg_we = 0, cfg_src_bus = 0, cfg_window = 0;
  logic [7:0] cfg_wdata = 0, svc_data = 0;
  logic svc_we = 0, stop_req = 0;
  logic [7:0] cfg_rdata;
  logic stop_go, rst_pulse;
  logic [1:0] rst_cause;

  int n_chk = 0, n_fail = 0;
  int n_ovf = 0, n_early = 0, n_stop = 0, n_go = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_watchdog #(.LP_E1(LE1), .LP_E2(LE2), .LP_E3(LE3),
                 .BUS_E1(BE1), .BUS_E2(BE2), .BUS_E3(BE3)) uut (
    .clk(clk), .rst(rst), .tick_lp(tick_lp), .tick_bus(tick_bus),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_src_bus(cfg_src_bus),
    .cfg_window(cfg_window), .cfg_rdata(cfg_rdata), .svc_we(svc_we),
    .svc_data(svc_data), .stop_req(stop_req), .stop_go(stop_go),
    .rst_pulse(rst_pulse), .rst_cause(rst_cause)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_reg;
  bit m_lock, m_src, m_win, m_arm, m_pulse, m_go;
  int m_cnt, m_cause;

  function automatic int period(input int code, input bit bus);
    int e;
    if (code == 0) return 0;
    if (bus) e = (code == 1) ? BE1 : (code == 2) ? BE2 : BE3;
    else     e = (code == 1) ? LE1 : (code == 2) ? LE2 : LE3;
    return 1 << e;
  endfunction

  always @(posedge clk) begin
    int code, per, wop;
    bit fin, tk, early, good, ovfl, illg;
    if (rst) begin
      m_reg <= 8'hC0; m_lock <= 0; m_src <= 0; m_win <= 0; m_arm <= 0;
      m_cnt <= 0; m_pulse <= 0; m_cause <= 0; m_go <= 0;
    end else begin
      code  = int'(m_reg[7:6]);
      per   = period(code, m_src);
      wop   = m_src ? per * 3 / 4 : 0;
      fin   = svc_we && svc_data == 8'hAA && m_arm;
      tk    = m_src ? tick_bus : tick_lp;
      early = code != 0 && fin && m_win && m_cnt < wop;
      good  = code != 0 && fin && !early;
      ovfl  = code != 0 && tk && m_cnt >= per - 1 && !good;
      illg  = stop_req && !m_reg[5];
      m_pulse <= illg || early || ovfl;
      m_cause <= illg ? 2 : early ? 1 : 0;
      m_go    <= stop_req && m_reg[5];
      if (svc_we) m_arm <= (svc_data == 8'h55);
      if (code == 0 || illg || early || ovfl || good) m_cnt <= 0;
      else if (tk) m_cnt <= m_cnt + 1;
      if (cfg_we && !m_lock) begin
        m_reg <= cfg_wdata & 8'hF8; m_src <= cfg_src_bus;
        m_win <= cfg_window; m_lock <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (rst_pulse !== m_pulse || (m_pulse && rst_cause !== 2'(m_cause))) begin
        n_fail++;
        $display("FAIL R4 model pulse/cause actual %0b/%0d expected %0b/%0d",
                 rst_pulse, rst_cause, m_pulse, m_cause);
      end
      n_chk++;
      if (stop_go !== m_go) begin
        n_fail++;
        $display("FAIL R9 model stop_go actual %0b expected %0b", stop_go, m_go);
      end
      n_chk++;
      if (cfg_rdata !== m_reg) begin
        n_fail++;
        $display("FAIL R2 model cfg_rdata actual %h expected %h", cfg_rdata, m_reg);
      end
      if (rst_pulse && rst_cause == 2'd0) n_ovf++;
      if (rst_pulse && rst_cause == 2'd1) n_early++;
      if (rst_pulse && rst_cause == 2'd2) n_stop++;
      if (stop_go) n_go++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic zero_counts();
    n_ovf = 0; n_early = 0; n_stop = 0; n_go = 0;
  endtask

  task automatic do_reset();
    rst = 1; step(); step(); step(); rst = 0;
  endtask

  task automatic ticks(input int n, input bit bus);
    for (int i = 0; i < n; i++) begin
      if (bus) tick_bus = 1; else tick_lp = 1;
      step();
      tick_bus = 0; tick_lp = 0;
    end
  endtask

  task automatic svc(input logic [7:0] d, input bit tk_bus);
    svc_we = 1; svc_data = d; tick_bus = tk_bus;
    step();
    svc_we = 0; tick_bus = 0;
  endtask

  task automatic cfg_write(input logic [7:0] d, input bit src, input bit win);
    cfg_we = 1; cfg_wdata = d; cfg_src_bus = src; cfg_window = win;
    step();
    cfg_we = 0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 reset readback", int'(cfg_rdata), 'hC0);
    chk("R1 reset no pulse", int'(rst_pulse), 0);

    // R4 default: code 11, low-power tick, period 16
    zero_counts();
    ticks(15, 0);
    chk("R4 no overflow before period", n_ovf, 0);
    ticks(1, 0);
    chk("R4 overflow on 16th tick", n_ovf, 1);
    chk("r4_pulse one cycle", int'(rst_pulse), 1);
    step();
    chk("R4 pulse ends", int'(rst_pulse), 0);

    // R6 valid service restarts the period
    zero_counts();
    ticks(10, 0); svc(8'h55, 0); svc(8'hAA, 0); ticks(10, 0);
    chk("R6 serviced, no overflow", n_ovf, 0);
    ticks(6, 0);
    chk("R6 overflow 16 ticks after service", n_ovf, 1);
    // R6 broken sequence does not clear
    zero_counts();
    ticks(10, 0); svc(8'h55, 0); svc(8'h12, 0); svc(8'hAA, 0); ticks(5, 0);
    chk("R6 broken sequence no clear (pre)", n_ovf, 0);
    ticks(1, 0);
    chk("R6 broken sequence overflow", n_ovf, 1);

    // R1 first write: code 01, stop enable, bit 3; bus source, window on
    cfg_write(8'h6F, 1, 1);
    chk("R1 first write readback", int'(cfg_rdata), 'h68);
    // R2 later write ignored
    cfg_write(8'hFF, 0, 0);
    chk("R2 second write ignored", int'(cfg_rdata), 'h68);

    // R5 low-power ticks ignored, bus period 16
    zero_counts();
    ticks(40, 0);
    chk("R5 lp ticks ignored", n_ovf, 0);
    ticks(15, 1);
    chk("R5 bus no overflow at 15", n_ovf, 0);
    ticks(1, 1);
    chk("R5 bus overflow at 16", n_ovf, 1);

    // R7 early service in window mode
    zero_counts();
    ticks(5, 1); svc(8'h55, 0); svc(8'hAA, 0);
    chk("R7 early service cause 1", n_early, 1);
    ticks(13, 1); svc(8'h55, 0); svc(8'hAA, 0);
    chk("R7 in-window service quiet", n_early, 0 + 1);
    ticks(15, 1);
    chk("R7 no overflow after good service", n_ovf, 0);

    // R8 service completes on the overflow tick
    zero_counts();
    svc(8'h55, 0); svc(8'hAA, 1);
    chk("R8 service wins over overflow", n_ovf + n_early, 0);
    ticks(15, 1);
    chk("R8 fresh period (pre)", n_ovf, 0);
    ticks(1, 1);
    chk("R8 fresh period overflow", n_ovf, 1);

    // R9 stop enabled
    zero_counts();
    stop_req = 1; step(); stop_req = 0;
    chk("R9 stop granted", n_go, 1);
    chk("R9 no illegal stop", n_stop, 0);

    // R3 disabled, R9 illegal stop while disabled
    do_reset();
    cfg_write(8'h00, 0, 0);
    chk("R3 readback disabled", int'(cfg_rdata), 0);
    zero_counts();
    ticks(40, 0); ticks(40, 1);
    svc(8'h55, 0); svc(8'hAA, 0);
    chk("R3 disabled no pulse", n_ovf + n_early, 0);
    stop_req = 1; step(); stop_req = 0;
    chk("R9 illegal stop cause 2", n_stop, 1);
    chk("R9 no grant when disabled", n_go, 0);

    // R10 illegal stop coincides with overflow
    do_reset();
    zero_counts();
    ticks(15, 0);
    tick_lp = 1; stop_req = 1; step(); tick_lp = 0; stop_req = 0;
    chk("R10 single pulse cause 2", n_stop, 1);
    chk("R10 no overflow cause", n_ovf, 0);
    ticks(15, 0);
    chk("R10 counter cleared (pre)", n_ovf, 0);
    ticks(1, 0);
    chk("R10 overflow after fresh period", n_ovf, 1);

    step();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule